// File: doc/BRIEF.md
# CAN FD Transmit Descriptor Ring Reader

This block pulls pending transmit frames out of a circular buffer in memory and hands them, one whole frame at a time, to a CAN FD protocol engine. Software places frames in the ring as 16-byte descriptors and moves a write pointer. The block keeps its own read pointer. While it is enabled and the two pointers differ, it reads the descriptor header through a 64-bit memory read port and decodes the identifier, the remote and extended flags, the DLC and the FD options. It then fetches the payload words and offers the complete frame on a valid/ready handshake.

A classic frame always occupies one descriptor. An FD frame with a long payload spills its data words into the following descriptors, and those words may wrap past the ring end to offset zero. The read pointer moves only when the engine accepts the frame. It then advances by the number of descriptors the frame used and wraps by subtracting the ring size.

Top module: `canfd_txring_reader`

## Requirements
- R1: After reset, readPtr is 0, frmValid is 0 and memReq is 0.
- R2: No memory read is issued while enable is low, or while readPtr equals writePtr with no frame in progress.
- R3: A descriptor header is the 64-bit word at the descriptor offset. Its bits 31:0 form header word A and its bits 63:32 form header word B. In word A, bit 31 set marks an extended identifier, taken from bits 28:0, and bit 30 set marks a remote frame. With bit 31 clear, the standard identifier is bits 28:18, zero-extended on frmId.
- R4: In header word B, bits 31:28 carry the DLC, shown unchanged on frmDlc. Bit 25 marks an FD frame (frmFd) and bit 26 requests bit-rate switching (frmBrs).
- R5: For an FD frame, frmLen equals the DLC for codes 0..8. Codes 9..15 map to 12, 16, 20, 24, 32, 48 and 64 bytes.
- R6: For a classic frame with a DLC above 8, frmLen is 8 and frmDlc keeps the original code.
- R7: The payload is ceil(frmLen/8) 64-bit words, read from the consecutive 8-byte offsets that follow the header. Word i appears on frmData[64*i+63:64*i], and all words beyond the payload read as zero.
- R8: Every memAddr is a multiple of 8 below ringSize. An address that would reach ringSize becomes 0 instead.
- R9: While frmValid is high and frmReady is low, every frame output and readPtr hold their values.
- R10: When a frame is accepted, readPtr advances by 16 bytes per descriptor, wrapped by subtracting ringSize. A classic frame counts as 1 descriptor and an FD frame as 1 + ((frmLen + 7) >> 4). readPtr changes at no other time.
- R11: At most one memory read is outstanding. memReq is never raised while an earlier request still awaits memRvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows a new frame fetch to start |
| ringSize | input | PTR_W | Ring size in bytes, a multiple of 16 |
| writePtr | input | PTR_W | Software write pointer, byte offset |
| readPtr | output | PTR_W | Hardware read pointer, byte offset |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | PTR_W | Byte offset of the 64-bit word to read |
| memRvalid | input | 1 | Read data valid, one pulse per request |
| memRdata | input | 64 | Read data |
| frmValid | output | 1 | Frame available |
| frmReady | input | 1 | Engine accepts the frame |
| frmExt | output | 1 | Extended identifier |
| frmRtr | output | 1 | Remote frame |
| frmFd | output | 1 | FD frame |
| frmBrs | output | 1 | Bit-rate switch requested |
| frmId | output | 29 | Identifier |
| frmDlc | output | 4 | DLC code as stored |
| frmLen | output | 7 | Payload length in bytes |
| frmData | output | 512 | Payload words, word 0 in the low bits |

## Verification
The bench builds the block with PTR_W = 8 and drives a ring size of 128 bytes, which holds eight descriptors. With this size, a 64-byte FD frame fills most of the ring. The frame after it puts its header in the last descriptor, so its second payload word wraps to offset 0 and its read pointer update wraps as well. Both wrap paths are therefore exercised within a handful of frames. The memory model answers each request two cycles later, so the single-outstanding-read rule and the wait states are exercised on every fetch.

// File: rtl/canfd_txring_pkg.sv
package canfd_txring_pkg;
  localparam int WORD_W     = 64;
  localparam int MAX_WORDS  = 8;
  localparam int DESC_BYTES = 16;
  localparam int ID_W       = 29;

  typedef struct packed {
    logic load;     // copy read pointer into fetch cursor
    logic step;     // advance fetch cursor by one word
    logic capHdr;   // capture header fields
    logic capPay;   // capture one payload word
    logic advance;  // frame accepted, move read pointer
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR_REQ, ST_HDR_WAIT, ST_CHECK,
    ST_PAY_REQ, ST_PAY_WAIT, ST_PRESENT
  } rdState_t;

  function automatic logic [6:0] dlcToLen(input logic [3:0] dlc, input logic fd);
    logic [6:0] len;
    if (dlc <= 4'd8)   len = {3'b000, dlc};
    else if (!fd)      len = 7'd8;
    else begin
      case (dlc)
        4'd9:    len = 7'd12;
        4'd10:   len = 7'd16;
        4'd11:   len = 7'd20;
        4'd12:   len = 7'd24;
        4'd13:   len = 7'd32;
        4'd14:   len = 7'd48;
        default: len = 7'd64;
      endcase
    end
    return len;
  endfunction
endpackage

// File: rtl/canfd_txring_ctrl.sv
module canfd_txring_ctrl
  import canfd_txring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        ringEmpty,
  input  logic        payDone,
  input  logic        memRvalid,
  input  logic        frmReady,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        frmValid
);
  rdState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    frmValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable && !ringEmpty) begin
          strobe.load = 1'b1;
          stateNext   = ST_HDR_REQ;
        end
      end
      ST_HDR_REQ: begin
        memReq      = 1'b1;
        strobe.step = 1'b1;
        stateNext   = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: begin
        if (memRvalid) begin
          strobe.capHdr = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        stateNext = payDone ? ST_PRESENT : ST_PAY_REQ;
      end
      ST_PAY_REQ: begin
        memReq      = 1'b1;
        strobe.step = 1'b1;
        stateNext   = ST_PAY_WAIT;
      end
      ST_PAY_WAIT: begin
        if (memRvalid) begin
          strobe.capPay = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_PRESENT: begin
        frmValid = 1'b1;
        if (frmReady) begin
          strobe.advance = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/canfd_txring_dpath.sv
module canfd_txring_dpath
  import canfd_txring_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [PTR_W-1:0]            ringSize,
  input  logic [PTR_W-1:0]            writePtr,
  input  logic [WORD_W-1:0]           memRdata,
  output logic                        ringEmpty,
  output logic                        payDone,
  output logic [PTR_W-1:0]            memAddr,
  output logic [PTR_W-1:0]            readPtr,
  output logic                        frmExt,
  output logic                        frmRtr,
  output logic                        frmFd,
  output logic                        frmBrs,
  output logic [ID_W-1:0]             frmId,
  output logic [3:0]                  frmDlc,
  output logic [6:0]                  frmLen,
  output logic [WORD_W*MAX_WORDS-1:0] frmData
);
  localparam int SUM_W = PTR_W + 1;
  localparam int IDX_W = $clog2(MAX_WORDS) + 1;

  logic [PTR_W-1:0]  cursor, rdPtr;
  logic              hdrExt, hdrRtr, hdrFd, hdrBrs;
  logic [ID_W-1:0]   hdrId;
  logic [3:0]        hdrDlc;
  logic [IDX_W-1:0]  wIdx;
  logic [WORD_W-1:0] payload [MAX_WORDS];

  logic [6:0]        lenBytes;
  logic [7:0]        lenRound;
  logic [IDX_W-1:0]  numWords;
  logic [2:0]        descCount;
  logic [SUM_W-1:0]  cursorSum, ptrSum, sizeExt;
  logic [PTR_W-1:0]  cursorNext, ptrNext;

  assign sizeExt   = {1'b0, ringSize};
  assign lenBytes  = dlcToLen(hdrDlc, hdrFd);
  assign lenRound  = {1'b0, lenBytes} + 8'd7;
  assign numWords  = lenRound[3 +: IDX_W];
  assign descCount = hdrFd ? (3'd1 + lenRound[6:4]) : 3'd1;

  // cursor step: next 8-byte word, wrapping to offset zero at the ring end
  assign cursorSum  = {1'b0, cursor} + SUM_W'(8);
  assign cursorNext = (cursorSum >= sizeExt) ? '0 : cursorSum[PTR_W-1:0];

  // read pointer advance by whole descriptors, wrapped by subtracting the size
  assign ptrSum  = {1'b0, rdPtr} + SUM_W'({descCount, 4'b0000});
  always_comb begin
    if (ptrSum >= sizeExt) ptrNext = PTR_W'(ptrSum - sizeExt);
    else                   ptrNext = ptrSum[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      cursor <= '0;
    end else begin
      if (strobe.load)         cursor <= rdPtr;
      else if (strobe.step)    cursor <= cursorNext;
      if (strobe.advance)      rdPtr  <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrExt <= 1'b0;
      hdrRtr <= 1'b0;
      hdrFd  <= 1'b0;
      hdrBrs <= 1'b0;
      hdrId  <= '0;
      hdrDlc <= '0;
      wIdx   <= '0;
    end else if (strobe.capHdr) begin
      hdrExt <= memRdata[31];
      hdrRtr <= memRdata[30];
      hdrId  <= memRdata[31] ? memRdata[28:0] : {18'd0, memRdata[28:18]};
      hdrDlc <= memRdata[63:60];
      hdrBrs <= memRdata[58];
      hdrFd  <= memRdata[57];
      wIdx   <= '0;
    end else if (strobe.capPay) begin
      wIdx   <= wIdx + 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                         payload[w] <= '0;
        else if (strobe.capHdr)                            payload[w] <= '0;
        else if (strobe.capPay && wIdx == IDX_W'(w))       payload[w] <= memRdata;
      end
      assign frmData[WORD_W*w +: WORD_W] = payload[w];
    end
  endgenerate

  assign ringEmpty = (rdPtr == writePtr);
  assign payDone   = (wIdx == numWords);
  assign memAddr   = cursor;
  assign readPtr   = rdPtr;
  assign frmExt    = hdrExt;
  assign frmRtr    = hdrRtr;
  assign frmFd     = hdrFd;
  assign frmBrs    = hdrBrs;
  assign frmId     = hdrId;
  assign frmDlc    = hdrDlc;
  assign frmLen    = lenBytes;
endmodule

// File: rtl/canfd_txring_reader.sv
module canfd_txring_reader
  import canfd_txring_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic [PTR_W-1:0]            ringSize,
  input  logic [PTR_W-1:0]            writePtr,
  output logic [PTR_W-1:0]            readPtr,
  output logic                        memReq,
  output logic [PTR_W-1:0]            memAddr,
  input  logic                        memRvalid,
  input  logic [WORD_W-1:0]           memRdata,
  output logic                        frmValid,
  input  logic                        frmReady,
  output logic                        frmExt,
  output logic                        frmRtr,
  output logic                        frmFd,
  output logic                        frmBrs,
  output logic [ID_W-1:0]             frmId,
  output logic [3:0]                  frmDlc,
  output logic [6:0]                  frmLen,
  output logic [WORD_W*MAX_WORDS-1:0] frmData
);
  ctrlStrobe_t strobe;
  logic        ringEmpty, payDone;

  canfd_txring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .ringEmpty(ringEmpty),
    .payDone(payDone), .memRvalid(memRvalid), .frmReady(frmReady),
    .strobe(strobe), .memReq(memReq), .frmValid(frmValid)
  );

  canfd_txring_dpath #(.PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ringSize(ringSize),
    .writePtr(writePtr), .memRdata(memRdata), .ringEmpty(ringEmpty),
    .payDone(payDone), .memAddr(memAddr), .readPtr(readPtr),
    .frmExt(frmExt), .frmRtr(frmRtr), .frmFd(frmFd), .frmBrs(frmBrs),
    .frmId(frmId), .frmDlc(frmDlc), .frmLen(frmLen), .frmData(frmData)
  );
endmodule

// File: rtl/canfd_txring_reader_chk.sv
module canfd_txring_reader_chk
  import canfd_txring_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [PTR_W-1:0]            ringSize,
  input logic [PTR_W-1:0]            readPtr,
  input logic                        memReq,
  input logic [PTR_W-1:0]            memAddr,
  input logic                        memRvalid,
  input logic                        frmValid,
  input logic                        frmReady,
  input logic                        frmFd,
  input logic [ID_W-1:0]             frmId,
  input logic [3:0]                  frmDlc,
  input logic [6:0]                  frmLen,
  input logic [WORD_W*MAX_WORDS-1:0] frmData
);
  logic readPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          readPending <= 1'b0;
    else if (memReq)    readPending <= 1'b1;
    else if (memRvalid) readPending <= 1'b0;
  end

  assert_single_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !readPending);

  assert_addr_in_ring_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'b000) && (memAddr < ringSize));

  assert_hold_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmReady) |=> frmValid && $stable(frmId) && $stable(frmLen)
                                && $stable(frmData) && $stable(readPtr));

  assert_ptr_moves_on_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readPtr) |-> $past(frmValid && frmReady));

  assert_classic_len_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmFd) |-> (frmLen <= 7'd8));

  assert_fd_long_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmFd && frmDlc > 4'd8) |-> (frmLen > 7'd8) && (frmLen[1:0] == 2'b00));
endmodule

bind canfd_txring_reader canfd_txring_reader_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ringSize(ringSize), .readPtr(readPtr),
  .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid),
  .frmValid(frmValid), .frmReady(frmReady), .frmFd(frmFd), .frmId(frmId),
  .frmDlc(frmDlc), .frmLen(frmLen), .frmData(frmData)
);

// File: tb/canfd_txring_reader_test.sv
`timescale 1ns/1ps
module canfd_txring_reader_test;
  localparam int PTR_W = 8;
  localparam int RING  = 128;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic [PTR_W-1:0] ringSize = PTR_W'(RING), writePtr = '0, readPtr, memAddr;
  logic memReq, memRvalid = 1'b0, frmValid, frmReady = 1'b0;
  logic [63:0] memRdata = '0;
  logic frmExt, frmRtr, frmFd, frmBrs;
  logic [28:0] frmId;
  logic [3:0] frmDlc;
  logic [6:0] frmLen;
  logic [511:0] frmData;

  canfd_txring_reader #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ringSize(ringSize),
    .writePtr(writePtr), .readPtr(readPtr), .memReq(memReq), .memAddr(memAddr),
    .memRvalid(memRvalid), .memRdata(memRdata), .frmValid(frmValid),
    .frmReady(frmReady), .frmExt(frmExt), .frmRtr(frmRtr), .frmFd(frmFd),
    .frmBrs(frmBrs), .frmId(frmId), .frmDlc(frmDlc), .frmLen(frmLen),
    .frmData(frmData)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [63:0] mem [16];
  int reqCount = 0;
  logic [PTR_W-1:0] addrLog [16];
  int lat = 0;
  logic [PTR_W-1:0] addrQ = '0;

  // memory model: answers two cycles after each request
  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (memReq) begin
      if (reqCount < 16) addrLog[reqCount] <= memAddr;
      reqCount <= reqCount + 1;
      addrQ <= memAddr;
      lat <= 2;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        memRvalid <= 1'b1;
        memRdata  <= mem[addrQ[6:3]];
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkHdr(input logic ext, input logic rtr, input logic [28:0] id,
                                        input logic [3:0] dlc, input logic fd, input logic brs);
    logic [31:0] a, b;
    a = ext ? {1'b1, rtr, 1'b0, id} : {1'b0, rtr, 1'b0, id[10:0], 18'd0};
    b = {dlc, 1'b0, brs, fd, 25'd0};
    return {b, a};
  endfunction

  function automatic logic [63:0] payWord(input int f, input int k);
    return 64'hC0DE_0000_0000_0000 | (64'(f) << 16) | 64'(k);
  endfunction

  task automatic putFrame(input int off, input logic [63:0] hdr, input int f, input int nWords);
    mem[off / 8] = hdr;
    for (int k = 0; k < nWords; k++) mem[((off + 8 + 8 * k) % RING) / 8] = payWord(f, k);
  endtask

  task automatic waitFrame(input string req);
    int n = 0;
    while (!frmValid && n < 200) begin @(negedge clk); n++; end
    check(req, "frame presented", frmValid, 1);
  endtask

  task automatic checkWords(input string req, input int f, input int nWords);
    for (int k = 0; k < 8; k++)
      check(req, $sformatf("word %0d", k), frmData[64*k +: 64],
            (k < nWords) ? payWord(f, k) : 64'd0);
  endtask

  task automatic accept();
    frmReady = 1'b1;
    @(negedge clk);
    frmReady = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "readPtr", readPtr, 0);
    check("R1", "frmValid", frmValid, 0);
    check("R1", "memReq", memReq, 0);
  endtask

  task automatic testDisabled();
    putFrame(0, mkHdr(1'b0, 1'b0, 29'h5A3, 4'd3, 1'b0, 1'b0), 1, 1);
    writePtr = 8'd16;
    repeat (20) @(negedge clk);
    check("R2", "no request while disabled", reqCount, 0);
    check("R2", "readPtr while disabled", readPtr, 0);
  endtask

  task automatic testClassicStd();
    enable = 1'b1;
    waitFrame("R3");
    check("R3", "ext", frmExt, 0);
    check("R3", "rtr", frmRtr, 0);
    check("R3", "std id", frmId, 29'h5A3);
    check("R4", "dlc", frmDlc, 3);
    check("R4", "fd", frmFd, 0);
    check("R7", "len", frmLen, 3);
    checkWords("R7", 1, 1);
    accept();
    check("R10", "ptr after classic", readPtr, 16);
  endtask

  task automatic testClassicExtLong();
    putFrame(16, mkHdr(1'b1, 1'b1, 29'h0ABC_DE01, 4'd12, 1'b0, 1'b0), 2, 1);
    writePtr = 8'd32;
    waitFrame("R6");
    check("R3", "ext", frmExt, 1);
    check("R3", "rtr", frmRtr, 1);
    check("R3", "ext id", frmId, 29'h0ABC_DE01);
    check("R6", "dlc kept", frmDlc, 12);
    check("R6", "len capped", frmLen, 8);
    checkWords("R6", 2, 1);
    accept();
    check("R10", "ptr after classic dlc12", readPtr, 32);
  endtask

  task automatic testFdLongBackpressure();
    putFrame(32, mkHdr(1'b0, 1'b0, 29'h123, 4'd15, 1'b1, 1'b1), 3, 8);
    writePtr = 8'd112;
    waitFrame("R5");
    check("R4", "fd", frmFd, 1);
    check("R4", "brs", frmBrs, 1);
    check("R5", "len dlc15", frmLen, 64);
    checkWords("R7", 3, 8);
    repeat (5) @(negedge clk);
    check("R9", "valid held", frmValid, 1);
    check("R9", "ptr held", readPtr, 32);
    check("R9", "id held", frmId, 29'h123);
    accept();
    check("R10", "ptr after 5 descriptors", readPtr, 112);
  endtask

  task automatic testFdWrap();
    int base;
    putFrame(112, mkHdr(1'b0, 1'b0, 29'h7FF, 4'd9, 1'b1, 1'b0), 4, 2);
    base = reqCount;
    writePtr = 8'd16;
    waitFrame("R8");
    check("R5", "len dlc9", frmLen, 12);
    check("R4", "brs clear", frmBrs, 0);
    checkWords("R7", 4, 2);
    check("R8", "read count", reqCount - base, 3);
    check("R8", "header addr", addrLog[base], 112);
    check("R8", "word0 addr", addrLog[base + 1], 120);
    check("R8", "wrapped addr", addrLog[base + 2], 0);
    accept();
    check("R10", "ptr wrap", readPtr, 16);
  endtask

  task automatic testShortFrames();
    int base;
    putFrame(16, mkHdr(1'b0, 1'b0, 29'h001, 4'd0, 1'b0, 1'b0), 5, 0);
    base = reqCount;
    writePtr = 8'd32;
    waitFrame("R7");
    check("R7", "len zero", frmLen, 0);
    check("R7", "header only read", reqCount - base, 1);
    checkWords("R7", 5, 0);
    accept();
    check("R10", "ptr after empty frame", readPtr, 32);
    putFrame(32, mkHdr(1'b0, 1'b0, 29'h002, 4'd8, 1'b1, 1'b0), 6, 1);
    writePtr = 8'd48;
    waitFrame("R5");
    check("R5", "fd len 8", frmLen, 8);
    checkWords("R5", 6, 1);
    accept();
    check("R10", "fd one descriptor", readPtr, 48);
  endtask

  task automatic testEmptyStall();
    int base = reqCount;
    repeat (20) @(negedge clk);
    check("R2", "no request when empty", reqCount - base, 0);
    check("R2", "no frame when empty", frmValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDisabled();
    testClassicStd();
    testClassicExtLong();
    testFdLongBackpressure();
    testFdWrap();
    testShortFrames();
    testEmptyStall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule